// File: doc/BRIEF.md
# Link Rate and Lane Selector

This block picks the per-lane rate and the number of active lanes for a serial display link so that the link carries a requested aggregate data rate. It uses the fewest lanes and the lowest rate that still cover that data rate. It holds a two-entry rate table of 270000 and 162000 kB/s per lane. The table is ordered from high to low, and a zero entry past its end means that no rates remain. It starts at the top entry, or at the second entry when the encoder is limited to the low rate.

For each attempt, the block first reduces the lane count from the sink maximum. It halves the count as long as half the lanes at the current rate would still carry more than the requested rate. It then moves to a lower rate as long as the next rate, at that lane count, would still exceed the request. The block sets up the encoder-side controls and the two bytes for the sink configuration, then sends a one-cycle start to an external training sequencer. If training fails, the block steps to the next lower rate, fits the lane count again, and starts a new attempt. It stops when an attempt passes or when the table runs out, and reports the outcome with a one-cycle done pulse and a success flag.

Top module: `link_rate_sel`

## Requirements
- R1: After a start request, the first attempt uses the 270000 kB/s rate (rate code 8'h0A), unless `lowRateOnly` is high, in which case it begins at 162000 kB/s (code 8'h06).
- R2: Each attempt begins from `maxLanes` (1, 2 or 4) and halves the lane count while (lanes/2) times the current rate is greater than `reqRate`.
- R3: With the lane count settled, the rate moves to the next lower table entry while that entry times the lane count is greater than `reqRate`.
- R4: `linkCtrl` carries the lane-enable mask (2^lanes - 1) starting at bit 16, and the enhanced-framing enable at bit 14. All other bits are zero.
- R5: `clkSel` is 32'h0004_0000 at the 270000 kB/s rate and zero at 162000 kB/s.
- R6: `sinkCfg0` is the rate code (8'h0A or 8'h06). `sinkCfg1` is the lane count, with bit 7 set when enhanced framing was requested at start.
- R7: When training fails and a lower rate remains, a new attempt starts at that lower rate, with the lane count fitted again from `maxLanes`.
- R8: `done` pulses for one cycle. `success` is 1 when an attempt passed, and 0 when training failed at the lowest rate. `success` holds its value until the next result.
- R9: `trainStart` is high for exactly one cycle per attempt. It comes 3 cycles after `startReq` is sampled, or 2 cycles after a failing `trainDone` is sampled. `done` follows a final `trainDone` by 1 cycle.
- R10: While idle, all configuration outputs stay unchanged when inputs other than `startReq` change. A `startReq` that arrives during an operation is ignored.
- R11: After reset, `sinkCfg0`=8'h06, `sinkCfg1`=0, `linkCtrl`=0, `clkSel`=0, and `trainStart`, `done` and `success` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin a selection; sampled only when idle |
| reqRate | input | 32 | Required aggregate data rate, kB/s |
| maxLanes | input | 3 | Lanes the sink supports (1, 2 or 4) |
| lowRateOnly | input | 1 | Encoder limited to 162000 kB/s |
| enhFrame | input | 1 | Request enhanced framing |
| trainDone | input | 1 | Training sequencer result strobe |
| trainPass | input | 1 | Result qualifier, valid with trainDone |
| laneCount | output | 3 | Selected lane count |
| linkCtrl | output | 32 | Encoder link control word |
| clkSel | output | 32 | Encoder clock-select field |
| sinkCfg0 | output | 8 | Sink configuration byte: rate code |
| sinkCfg1 | output | 8 | Sink configuration byte: lanes and framing |
| trainStart | output | 1 | One-cycle request to start training |
| done | output | 1 | One-cycle completion pulse |
| success | output | 1 | Outcome of the last selection |

## Verification
Inputs are driven and outputs are sampled on the falling edge. The first `trainStart` is therefore checked on the third falling edge after `startReq` is driven. A retry `trainStart` is checked on the second falling edge after a failing `trainDone`, and `done` on the first falling edge after a final `trainDone`. The configuration outputs are compared while `trainStart` is high, and that level is checked against zero on the edge that follows. Idle stability is checked by changing the inputs other than `startReq` for several cycles and then comparing the outputs.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  localparam logic [7:0] CODE_HI = 8'h0A;
  localparam logic [7:0] CODE_LO = 8'h06;
  localparam logic [31:0] CLK_HI = 32'h0004_0000;

  typedef struct packed {
    logic init;  // load starting rate index, latch framing
    logic fit;   // apply lane/rate fit from current index
    logic next;  // advance to next lower rate
  } lrs_strobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_FIT, S_KICK, S_WAIT, S_FINISH
  } lrs_state_t;
endpackage

// File: rtl/lrs_datapath.sv
module lrs_datapath import lrs_pkg::*; #(
  parameter int MAX_LANES = 4,
  parameter int REQ_W = 32,
  parameter int RATE_HI = 270000,
  parameter int RATE_LO = 162000,
  localparam int LANE_W = $clog2(MAX_LANES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lrs_strobe_t       stb,
  input  logic [REQ_W-1:0]  reqRate,
  input  logic [LANE_W-1:0] maxLanes,
  input  logic              lowRateOnly,
  input  logic              enhFrame,
  output logic              lastRate,
  output logic [LANE_W-1:0] laneCount,
  output logic [31:0]       linkCtrl,
  output logic [31:0]       clkSel,
  output logic [7:0]        sinkCfg0,
  output logic [7:0]        sinkCfg1
);
  localparam int STEPS = $clog2(MAX_LANES);

  logic [1:0]        rateIdx;
  logic [LANE_W-1:0] lanes;
  logic              enhReg;
  logic [1:0]        fitIdx;
  logic [LANE_W-1:0] fitLanes;

  function automatic logic [63:0] rateAt(input logic [1:0] i);
    case (i)
      2'd0:    rateAt = 64'(RATE_HI);
      2'd1:    rateAt = 64'(RATE_LO);
      default: rateAt = 64'd0;
    endcase
  endfunction

  always_comb begin
    fitLanes = maxLanes;
    for (int s = 0; s < STEPS; s++) begin
      if (64'(fitLanes >> 1) * rateAt(rateIdx) > 64'(reqRate))
        fitLanes = fitLanes >> 1;
    end
    fitIdx = rateIdx;
    for (int s = 0; s < 2; s++) begin
      if (rateAt(fitIdx + 2'd1) * 64'(fitLanes) > 64'(reqRate))
        fitIdx = fitIdx + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rateIdx <= 2'd1;
      lanes   <= '0;
      enhReg  <= 1'b0;
    end else if (stb.init) begin
      rateIdx <= lowRateOnly ? 2'd1 : 2'd0;
      enhReg  <= enhFrame;
    end else if (stb.fit) begin
      rateIdx <= fitIdx;
      lanes   <= fitLanes;
    end else if (stb.next) begin
      rateIdx <= rateIdx + 2'd1;
    end
  end

  logic [31:0] laneMask;
  assign laneMask  = (32'd1 << lanes) - 32'd1;
  assign lastRate  = (rateAt(rateIdx + 2'd1) == 64'd0);
  assign laneCount = lanes;
  assign linkCtrl  = (laneMask << 16) | (32'(enhReg) << 14);
  assign clkSel    = (rateIdx == 2'd0) ? CLK_HI : 32'd0;
  assign sinkCfg0  = (rateIdx == 2'd0) ? CODE_HI : CODE_LO;
  assign sinkCfg1  = 8'(lanes) | {enhReg, 7'd0};
endmodule

// File: rtl/lrs_control.sv
module lrs_control import lrs_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        startReq,
  input  logic        trainDone,
  input  logic        trainPass,
  input  logic        lastRate,
  output lrs_strobe_t stb,
  output logic        trainStart,
  output logic        done,
  output logic        success
);
  lrs_state_t state, stateNxt;
  logic finish;

  assign finish = trainDone && (trainPass || lastRate);

  always_comb begin
    stateNxt = state;
    case (state)
      S_IDLE:   if (startReq) stateNxt = S_SETUP;
      S_SETUP:  stateNxt = S_FIT;
      S_FIT:    stateNxt = S_KICK;
      S_KICK:   stateNxt = S_WAIT;
      S_WAIT:   if (trainDone) stateNxt = finish ? S_FINISH : S_FIT;
      S_FINISH: stateNxt = S_IDLE;
      default:  stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      success <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == S_WAIT && finish) success <= trainPass;
    end
  end

  assign stb.init   = (state == S_SETUP);
  assign stb.fit    = (state == S_FIT);
  assign stb.next   = (state == S_WAIT) && trainDone && !finish;
  assign trainStart = (state == S_KICK);
  assign done       = (state == S_FINISH);
endmodule

// File: rtl/link_rate_sel.sv
module link_rate_sel import lrs_pkg::*; #(
  parameter int MAX_LANES = 4,
  parameter int RATE_HI = 270000,
  parameter int RATE_LO = 162000,
  localparam int LANE_W = $clog2(MAX_LANES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startReq,
  input  logic [31:0]       reqRate,
  input  logic [LANE_W-1:0] maxLanes,
  input  logic              lowRateOnly,
  input  logic              enhFrame,
  input  logic              trainDone,
  input  logic              trainPass,
  output logic [LANE_W-1:0] laneCount,
  output logic [31:0]       linkCtrl,
  output logic [31:0]       clkSel,
  output logic [7:0]        sinkCfg0,
  output logic [7:0]        sinkCfg1,
  output logic              trainStart,
  output logic              done,
  output logic              success
);
  lrs_strobe_t stb;
  logic        lastRate;

  lrs_control i_ctl (
    .clk(clk), .rst_n(rst_n), .startReq(startReq),
    .trainDone(trainDone), .trainPass(trainPass), .lastRate(lastRate),
    .stb(stb), .trainStart(trainStart), .done(done), .success(success)
  );

  lrs_datapath #(
    .MAX_LANES(MAX_LANES), .REQ_W(32), .RATE_HI(RATE_HI), .RATE_LO(RATE_LO)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .reqRate(reqRate),
    .maxLanes(maxLanes), .lowRateOnly(lowRateOnly), .enhFrame(enhFrame),
    .lastRate(lastRate), .laneCount(laneCount), .linkCtrl(linkCtrl),
    .clkSel(clkSel), .sinkCfg0(sinkCfg0), .sinkCfg1(sinkCfg1)
  );
endmodule

// File: rtl/lrs_checker.sv
module lrs_checker #(
  parameter int MAX_LANES = 4,
  localparam int LANE_W = $clog2(MAX_LANES) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              startReq,
  input logic [LANE_W-1:0] maxLanes,
  input logic [LANE_W-1:0] laneCount,
  input logic [31:0]       linkCtrl,
  input logic [31:0]       clkSel,
  input logic [7:0]        sinkCfg0,
  input logic [7:0]        sinkCfg1,
  input logic              trainStart,
  input logic              done,
  input logic              success
);
  logic idleFlag;
  always_ff @(posedge clk) begin
    if (!rst_n)        idleFlag <= 1'b1;
    else if (startReq) idleFlag <= 1'b0;
    else if (done)     idleFlag <= 1'b1;
  end

  p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trainStart |=> !trainStart);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_success_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !startReq |=> $stable(success));

  p_lanes_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trainStart |-> ($countones(laneCount) == 1) && (laneCount <= maxLanes));

  p_mask_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trainStart |-> ($countones(linkCtrl[31:16]) == int'(laneCount))
                   && ($countones(linkCtrl[13:0]) == 0));

  p_clk_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trainStart |-> ((clkSel != 32'd0) == (sinkCfg0 == 8'h0A)));

  p_cfg_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trainStart |-> (sinkCfg1[6:0] == 7'(laneCount))
                   && (sinkCfg1[7] == linkCtrl[14]));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    idleFlag && !startReq |=> $stable(linkCtrl) && $stable(clkSel)
                              && $stable(sinkCfg0) && $stable(sinkCfg1));
endmodule

bind link_rate_sel lrs_checker #(.MAX_LANES(MAX_LANES)) i_chk (
  .clk(clk), .rst_n(rst_n), .startReq(startReq), .maxLanes(maxLanes),
  .laneCount(laneCount), .linkCtrl(linkCtrl), .clkSel(clkSel),
  .sinkCfg0(sinkCfg0), .sinkCfg1(sinkCfg1), .trainStart(trainStart),
  .done(done), .success(success)
);

// File: tb/test_link_rate_sel.sv
module test_link_rate_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startReq = 1'b0;
  logic [31:0] reqRate = 32'd0;
  logic [2:0]  maxLanes = 3'd4;
  logic        lowRateOnly = 1'b0;
  logic        enhFrame = 1'b0;
  logic        trainDone = 1'b0;
  logic        trainPass = 1'b0;
  logic [2:0]  laneCount;
  logic [31:0] linkCtrl, clkSel;
  logic [7:0]  sinkCfg0, sinkCfg1;
  logic        trainStart, done, success;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  link_rate_sel i_link_rate_sel (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .reqRate(reqRate),
    .maxLanes(maxLanes), .lowRateOnly(lowRateOnly), .enhFrame(enhFrame),
    .trainDone(trainDone), .trainPass(trainPass), .laneCount(laneCount),
    .linkCtrl(linkCtrl), .clkSel(clkSel), .sinkCfg0(sinkCfg0),
    .sinkCfg1(sinkCfg1), .trainStart(trainStart), .done(done),
    .success(success)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic longint rateOf(input int i);
    if (i == 0) return 270000;
    if (i == 1) return 162000;
    return 0;
  endfunction

  // Expected configuration, derived from R2..R6
  task automatic checkCfg(input int idx, input longint lanes, input bit enh);
    longint mask = (longint'(1) << lanes) - 1;
    chk(laneCount == 3'(lanes), "R2 lane count", laneCount, lanes);
    chk(sinkCfg0 == ((idx == 0) ? 8'h0A : 8'h06), "R1/R3 rate code", sinkCfg0, (idx == 0) ? 8'h0A : 8'h06);
    chk(linkCtrl == 32'((mask << 16) | (longint'(enh) << 14)), "R4 link control", linkCtrl, (mask << 16) | (longint'(enh) << 14));
    chk(clkSel == ((idx == 0) ? 32'h0004_0000 : 32'd0), "R5 clock select", clkSel, (idx == 0) ? 32'h0004_0000 : 0);
    chk(sinkCfg1 == 8'(lanes | (longint'(enh) << 7)), "R6 sink lane byte", sinkCfg1, lanes | (longint'(enh) << 7));
  endtask

  task automatic runCase(input int maxL, input bit low, input longint req, input bit enh, input int failsBefore);
    int idx = low ? 1 : 0;
    int attempt = 0;
    longint lanes;
    bit pass, finalAttempt;
    maxLanes = 3'(maxL); lowRateOnly = low; reqRate = 32'(req); enhFrame = enh;
    startReq = 1'b1; tick(); startReq = 1'b0;
    chk(trainStart == 1'b0, "R9 no early start", trainStart, 0);
    tick(); tick();
    forever begin
      lanes = maxL;
      for (int s = 0; s < 2; s++) if ((lanes / 2) * rateOf(idx) > req) lanes = lanes / 2;
      while (rateOf(idx + 1) * lanes > req) idx++;
      chk(trainStart == 1'b1, "R9/R7 train start", trainStart, 1);
      checkCfg(idx, lanes, enh);
      tick();
      chk(trainStart == 1'b0, "R9 start one cycle", trainStart, 0);
      pass = (attempt == failsBefore);
      finalAttempt = pass || (idx == 1);
      trainDone = 1'b1; trainPass = pass;
      tick();
      trainDone = 1'b0; trainPass = 1'b0;
      if (finalAttempt) begin
        chk(done == 1'b1, "R9 done latency", done, 1);
        chk(success == pass, "R8 success flag", success, pass);
        tick();
        chk(done == 1'b0, "R8 done one cycle", done, 0);
        break;
      end
      chk(done == 1'b0, "R7 no done on retry", done, 0);
      tick();
      idx++;
      attempt++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    longint reqs[10] = '{100000, 162000, 200000, 270000, 324000,
                         500000, 540000, 700000, 1080000, 2000000};
    logic [31:0] sLink, sClk;
    logic [7:0]  s0, s1;
    repeat (3) tick();
    // R11 reset values
    chk(sinkCfg0 == 8'h06, "R11 reset rate code", sinkCfg0, 8'h06);
    chk(sinkCfg1 == 8'h00, "R11 reset lane byte", sinkCfg1, 0);
    chk(linkCtrl == 32'd0, "R11 reset link control", linkCtrl, 0);
    chk(clkSel == 32'd0, "R11 reset clock select", clkSel, 0);
    chk({trainStart, done, success} == 3'b000, "R11 reset strobes", {trainStart, done, success}, 0);
    rst_n = 1'b1;
    tick();

    for (int m = 0; m < 3; m++)
      for (int lo = 0; lo < 2; lo++)
        for (int r = 0; r < 10; r++)
          for (int e = 0; e < 2; e++)
            for (int f = 0; f < 3; f++)
              runCase(1 << m, lo[0], reqs[r], e[0], f);

    // R10: idle outputs hold while other inputs move
    runCase(2, 1'b0, 300000, 1'b1, 0);
    sLink = linkCtrl; sClk = clkSel; s0 = sinkCfg0; s1 = sinkCfg1;
    maxLanes = 3'd4; reqRate = 32'd50; enhFrame = 1'b0; lowRateOnly = 1'b1;
    trainDone = 1'b1; trainPass = 1'b1;
    repeat (5) tick();
    trainDone = 1'b0; trainPass = 1'b0;
    chk({linkCtrl, clkSel, sinkCfg0, sinkCfg1} == {sLink, sClk, s0, s1}, "R10 idle hold",
        longint'(linkCtrl), longint'(sLink));
    chk(done == 1'b0 && trainStart == 1'b0, "R10 idle no strobes", {done, trainStart}, 0);

    // R10: start request during an operation is ignored
    maxLanes = 3'd4; lowRateOnly = 1'b0; reqRate = 32'd600000; enhFrame = 1'b0;
    startReq = 1'b1; tick(); startReq = 1'b0; tick(); tick();
    chk(trainStart == 1'b1, "R9 start latency", trainStart, 1);
    tick();
    startReq = 1'b1; tick(); startReq = 1'b0;
    trainDone = 1'b1; trainPass = 1'b1; tick();
    trainDone = 1'b0; trainPass = 1'b0;
    chk(done == 1'b1 && success == 1'b1, "R8 pass result", {done, success}, 3);
    begin
      bit sawStart = 0;
      for (int k = 0; k < 6; k++) begin
        tick();
        if (trainStart) sawStart = 1;
      end
      chk(!sawStart, "R10 busy start ignored", sawStart, 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule